// File: doc/BRIEF.md
# Byte-stream network port with register window

This block connects a host to a packet network one byte at a time. The host sees a 64-byte register window. It holds a fixed eight-character identifier, a busy flag, byte counters for each direction, an interrupt control word, a constant info word, and two single-byte data ports. On the network side, incoming and outgoing frames travel over valid/ready byte streams that carry an end-of-frame marker. Both directions are staged in an internal buffer of `DEPTH` bytes.

On receive, the block stores a frame and then publishes its length in the receive counter. Software drains the frame through the receive data port, and each read takes one byte and lowers the counter. Software then acknowledges the frame through the interrupt control register. The network side is held off until both the acknowledge and the drain are done. On transmit, software programs a length and pushes that many bytes. The block then plays the bytes out, clears the length and raises a transmit-done flag. A test bit lets software raise the interrupt line on demand.

Host accesses use a one-cycle strobe. Read data is combinational from the address. Side effects of a read, such as popping a byte or clearing the test bit, take effect at the clock edge that ends the access. Only word-aligned addresses are decoded.

Top module: `bnp_port`

## Requirements
- R1: The identifier reads as two words. Offset 0x00 holds the first four characters, with the first character in bits 7:0. Offset 0x04 holds the last four. With the default `ID_TEXT` of "BNETPORT" these words are 0x54454E42 and 0x54524F50.
- R2: Bit 0 of the busy word at offset 0x08 reads 1 while an incoming frame has been partly taken or an outgoing frame is being presented, and 0 otherwise. Writes to this word have no effect.
- R3: The receive counter at offset 0x0C keeps its value while a frame is arriving. On the cycle after the end-of-frame byte is accepted, it holds the frame's byte count, and interrupt control bit 1 (receive available) is set.
- R4: Each read of offset 0x1C while the receive counter is non-zero returns the next stored byte in arrival order in bits 7:0, with the upper bits at 0, and lowers the counter by one. A read while the counter is 0 returns 0 and changes nothing.
- R5: `rx_ready` is low while interrupt control bit 1 is set or the receive counter is non-zero. No byte is taken in that state.
- R6: A write to the transmit counter at offset 0x10 while no frame is being sent sets the length, capped at `DEPTH`, and restarts the byte fill. Bits 7:0 of each write to offset 0x20 are stored. Data writes beyond the length, and length writes while a frame is being sent, are ignored.
- R7: Once the programmed number of bytes has been written, the outgoing stream presents exactly those bytes in write order, with `tx_last` on the final byte. Each byte is held stable while `tx_ready` is low.
- R8: On the cycle after the final outgoing byte is accepted, the transmit counter reads 0 and interrupt control bit 0 (transmit done) is set.
- R9: Interrupt control bits 0 and 1 are cleared by writing 1 to them. Writing 0 to them leaves them unchanged.
- R10: Writing 1 to interrupt control bit 31 sets the test flag and writing 0 to it clears the flag. A read of the interrupt control word returns the flag's current value and then clears it.
- R11: The `irq` output is the OR of interrupt control bits 0, 1 and 31.
- R12: Offset 0x18 reads as `INFO_WORD` (default 0x00000007). Writes to it are ignored. The transmit data port, undecoded offsets and misaligned addresses read as 0.
- R13: Bytes of an incoming frame beyond `DEPTH` are dropped, and the receive counter then shows `DEPTH` (64 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 6 | Byte address inside the window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for the current address |
| irq | output | 1 | Interrupt request to the host |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends its frame |
| rx_ready | output | 1 | Block can take an incoming byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends its frame |
| tx_ready | input | 1 | Network side takes the outgoing byte |

## Verification
The bound checker watches several properties on every cycle. It confirms that the receive side holds off while a frame is unacknowledged or undrained, that an end-of-frame sets the receive flag, that each pop lowers the counter by exactly one, that a stalled outgoing byte stays put, that the last accepted byte clears the transmit length and sets the done flag, and that a test write raises the interrupt. The bench's reference model follows `irq`, `rx_ready` and `tx_valid` every clock and checks each outgoing byte against the written order. Only the scripted scenarios can show the read values themselves. These include the identifier layout, the cap on programmed lengths, truncation of oversize frames, the ignored writes, and the read-clears behaviour of the test bit.

// File: rtl/bnp_pkg.sv
package bnp_pkg;

   localparam int BYTE_W  = 8;
   localparam int WORD_W  = 32;
   localparam int WIN_AW  = 6;    // 64-byte register window
   localparam int MAX_LEN = 65536;

   // word index = byte address / 4
   typedef enum logic [3:0] {
      REG_ID_LO  = 4'd0,
      REG_ID_HI  = 4'd1,
      REG_BUSY   = 4'd2,
      REG_RX_CNT = 4'd3,
      REG_TX_CNT = 4'd4,
      REG_INT    = 4'd5,
      REG_INFO   = 4'd6,
      REG_RX_DAT = 4'd7,
      REG_TX_DAT = 4'd8
   } bnp_reg_e;

   localparam int IRQ_TX_BIT   = 0;
   localparam int IRQ_RX_BIT   = 1;
   localparam int IRQ_TEST_BIT = 31;

endpackage

// File: rtl/bnp_rx_buf.sv
module bnp_rx_buf #(
   parameter int DEPTH = 64,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int AW = $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [bnp_pkg::BYTE_W-1:0] in_data,
   input  logic                       in_last,
   output logic                       in_ready,
   input  logic                       hold,
   input  logic                       pop,
   output logic                       frame_done,
   output logic                       in_frame,
   output logic [CW-1:0]              count,
   output logic [bnp_pkg::BYTE_W-1:0] rd_byte
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic [bnp_pkg::BYTE_W-1:0] mem [DEPTH];
   logic [CW-1:0]              wr_cnt;
   logic [CW-1:0]              next_len;
   logic [AW-1:0]              rd_ptr;
   logic                       accept;
   logic                       room;

   assign in_ready   = !hold && (count == '0);
   assign accept     = in_valid && in_ready;
   assign room       = (wr_cnt < DEPTH_C);
   assign next_len   = room ? wr_cnt + CW'(1) : wr_cnt;
   assign frame_done = accept && in_last;
   assign rd_byte    = (count != '0) ? mem[rd_ptr] : '0;

   always_ff @(posedge clk) begin
      if (accept && room) begin
         mem[wr_cnt[AW-1:0]] <= in_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_cnt   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         in_frame <= 1'b0;
      end else if (accept) begin
         if (in_last) begin
            count    <= next_len;
            wr_cnt   <= '0;
            rd_ptr   <= '0;
            in_frame <= 1'b0;
         end else begin
            wr_cnt   <= next_len;
            in_frame <= 1'b1;
         end
      end else if (pop && (count != '0)) begin
         count  <= count - CW'(1);
         rd_ptr <= rd_ptr + AW'(1);
      end
   end

endmodule

// File: rtl/bnp_tx_buf.sv
module bnp_tx_buf #(
   parameter int DEPTH = 64,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int AW = $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       len_we,
   input  logic [bnp_pkg::WORD_W-1:0] len_wdata,
   input  logic                       dat_we,
   input  logic [bnp_pkg::BYTE_W-1:0] dat_wdata,
   output logic                       out_valid,
   output logic [bnp_pkg::BYTE_W-1:0] out_data,
   output logic                       out_last,
   input  logic                       out_ready,
   output logic                       done,
   output logic                       sending,
   output logic [CW-1:0]              len
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic [bnp_pkg::BYTE_W-1:0] mem [DEPTH];
   logic [CW-1:0]              fill;
   logic [AW-1:0]              rd_ptr;
   logic                       store;

   assign store     = !sending && !len_we && dat_we && (fill < len);
   assign out_valid = sending;
   assign out_data  = mem[rd_ptr];
   assign out_last  = sending && (CW'(rd_ptr) == len - CW'(1));
   assign done      = sending && out_ready && out_last;

   always_ff @(posedge clk) begin
      if (store) begin
         mem[fill[AW-1:0]] <= dat_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len     <= '0;
         fill    <= '0;
         rd_ptr  <= '0;
         sending <= 1'b0;
      end else if (sending) begin
         if (out_ready) begin
            if (out_last) begin
               sending <= 1'b0;
               len     <= '0;
               fill    <= '0;
            end else begin
               rd_ptr <= rd_ptr + AW'(1);
            end
         end
      end else if (len_we) begin
         len  <= (len_wdata > bnp_pkg::WORD_W'(DEPTH)) ? DEPTH_C : len_wdata[CW-1:0];
         fill <= '0;
      end else if (store) begin
         fill <= fill + CW'(1);
      end else if ((len != '0) && (fill == len)) begin
         sending <= 1'b1;
         rd_ptr  <= '0;
      end
   end

endmodule

// File: rtl/bnp_irq.sv
module bnp_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_set,
   input  logic rx_set,
   input  logic clr_tx,
   input  logic clr_rx,
   input  logic test_wr,
   input  logic test_val,
   input  logic test_rd,
   output logic txd,
   output logic rxa,
   output logic test,
   output logic irq
);
   assign irq = txd | rxa | test;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txd  <= 1'b0;
         rxa  <= 1'b0;
         test <= 1'b0;
      end else begin
         txd <= tx_set | (txd & ~clr_tx);
         rxa <= rx_set | (rxa & ~clr_rx);
         if (test_wr) begin
            test <= test_val;
         end else if (test_rd) begin
            test <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/bnp_port.sv
module bnp_port #(
   parameter int          DEPTH     = 64,
   parameter logic [63:0] ID_TEXT   = 64'h424E_4554_504F_5254,
   parameter logic [31:0] INFO_WORD = 32'h0000_0007
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_req,
   input  logic        host_we,
   input  logic [5:0]  host_addr,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   output logic        irq,
   input  logic        rx_valid,
   input  logic [7:0]  rx_data,
   input  logic        rx_last,
   output logic        rx_ready,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   output logic        tx_last,
   input  logic        tx_ready
);
   import bnp_pkg::*;

   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int ID_CH  = 8;

   if (DEPTH < 2 || DEPTH > MAX_LEN) begin : g_bad_depth
      $error("bnp_port: DEPTH must lie between 2 and MAX_LEN");
   end

   // first character of the identifier text lands in the lowest byte
   logic [63:0] id_word;
   for (genvar gi = 0; gi < ID_CH; gi++) begin : g_id
      assign id_word[gi*BYTE_W +: BYTE_W] = ID_TEXT[(ID_CH-1-gi)*BYTE_W +: BYTE_W];
   end

   bnp_reg_e reg_sel;
   logic     word_ok, rd_hit, wr_hit;

   assign reg_sel = bnp_reg_e'(host_addr[WIN_AW-1:2]);
   assign word_ok = (host_addr[1:0] == 2'b00);
   assign rd_hit  = host_req && !host_we && word_ok;
   assign wr_hit  = host_req &&  host_we && word_ok;

   logic             rx_done, rx_in_frame;
   logic [CNT_W-1:0] rx_cnt;
   logic [7:0]       rx_byte;
   logic             tx_done, tx_sending;
   logic [CNT_W-1:0] tx_len;
   logic             irq_txd, irq_rxa, irq_test;
   logic             int_wr;

   assign int_wr = wr_hit && (reg_sel == REG_INT);

   bnp_rx_buf #(.DEPTH(DEPTH)) rx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (rx_valid),
      .in_data    (rx_data),
      .in_last    (rx_last),
      .in_ready   (rx_ready),
      .hold       (irq_rxa),
      .pop        (rd_hit && (reg_sel == REG_RX_DAT)),
      .frame_done (rx_done),
      .in_frame   (rx_in_frame),
      .count      (rx_cnt),
      .rd_byte    (rx_byte)
   );

   bnp_tx_buf #(.DEPTH(DEPTH)) tx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .len_we    (wr_hit && (reg_sel == REG_TX_CNT)),
      .len_wdata (host_wdata),
      .dat_we    (wr_hit && (reg_sel == REG_TX_DAT)),
      .dat_wdata (host_wdata[7:0]),
      .out_valid (tx_valid),
      .out_data  (tx_data),
      .out_last  (tx_last),
      .out_ready (tx_ready),
      .done      (tx_done),
      .sending   (tx_sending),
      .len       (tx_len)
   );

   bnp_irq irq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_set   (tx_done),
      .rx_set   (rx_done),
      .clr_tx   (int_wr && host_wdata[IRQ_TX_BIT]),
      .clr_rx   (int_wr && host_wdata[IRQ_RX_BIT]),
      .test_wr  (int_wr),
      .test_val (host_wdata[IRQ_TEST_BIT]),
      .test_rd  (rd_hit && (reg_sel == REG_INT)),
      .txd      (irq_txd),
      .rxa      (irq_rxa),
      .test     (irq_test),
      .irq      (irq)
   );

   always_comb begin
      host_rdata = '0;
      if (word_ok) begin
         case (reg_sel)
            REG_ID_LO:  host_rdata = id_word[31:0];
            REG_ID_HI:  host_rdata = id_word[63:32];
            REG_BUSY:   host_rdata = {31'b0, rx_in_frame | tx_sending};
            REG_RX_CNT: host_rdata = WORD_W'(rx_cnt);
            REG_TX_CNT: host_rdata = WORD_W'(tx_len);
            REG_INT:    host_rdata = {irq_test, 29'b0, irq_rxa, irq_txd};
            REG_INFO:   host_rdata = INFO_WORD;
            REG_RX_DAT: host_rdata = {24'b0, rx_byte};
            default:    host_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/bnp_port_chk.sv
module bnp_port_chk #(
   parameter int CW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_pop,
   input logic          test_wr,
   input logic          rx_valid,
   input logic          rx_ready,
   input logic          rx_last,
   input logic          tx_valid,
   input logic          tx_ready,
   input logic          tx_last,
   input logic [7:0]    tx_data,
   input logic          rxa,
   input logic          txd,
   input logic          irq,
   input logic [CW-1:0] rx_cnt,
   input logic [CW-1:0] tx_len
);
   // R5
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rxa || (rx_cnt != '0)) |-> !rx_ready);

   // R3
   rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready && rx_last) |=> rxa);

   // R4
   rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && (rx_cnt != '0)) |=> (rx_cnt == CW'($past(rx_cnt) - 1'b1)));

   // R7
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   // R8
   tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> (txd && (tx_len == '0)));

   // R10
   test_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_wr |=> irq);

endmodule

bind bnp_port bnp_port_chk #(.CW(CNT_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_pop   (rd_hit && (reg_sel == bnp_pkg::REG_RX_DAT)),
   .test_wr  (int_wr && host_wdata[bnp_pkg::IRQ_TEST_BIT]),
   .rx_valid (rx_valid),
   .rx_ready (rx_ready),
   .rx_last  (rx_last),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .tx_last  (tx_last),
   .tx_data  (tx_data),
   .rxa      (irq_rxa),
   .txd      (irq_txd),
   .irq      (irq),
   .rx_cnt   (rx_cnt),
   .tx_len   (tx_len)
);

// File: tb/bnp_port_tb_top.sv
`timescale 1ns/1ps
module bnp_port_tb_top;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [5:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        irq;
   logic        rx_valid = 1'b0, rx_last = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready;
   logic        tx_valid, tx_last;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;

   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   bnp_port #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq(irq), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
      .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last), .tx_ready(tx_ready)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   bit         m_txd, m_rxa, m_test, m_send;
   int         m_rx_cnt, m_rx_pend, m_tx_len, m_tx_fill, m_tx_seen;
   logic [7:0] m_txq[$];

   always @(posedge clk) begin : model
      bit rd_s, wr_s, start_s;
      int idx_s;
      if (!rst_n) begin
         m_txd = 0; m_rxa = 0; m_test = 0; m_send = 0;
         m_rx_cnt = 0; m_rx_pend = 0; m_tx_len = 0; m_tx_fill = 0;
         m_txq.delete();
      end else begin
         rd_s  = host_req && !host_we && (host_addr[1:0] == 2'b00);
         wr_s  = host_req &&  host_we && (host_addr[1:0] == 2'b00);
         idx_s = int'(host_addr[5:2]);
         start_s = !m_send && (m_tx_len != 0) && (m_tx_fill == m_tx_len)
                   && !(wr_s && idx_s == 4);
         if (wr_s && idx_s == 5 && host_wdata[0]) m_txd = 0;
         if (wr_s && idx_s == 5 && host_wdata[1]) m_rxa = 0;
         if (rx_valid && rx_ready) begin
            if (m_rx_pend < DEPTH) m_rx_pend++;
            if (rx_last) begin
               m_rx_cnt = m_rx_pend; m_rx_pend = 0; m_rxa = 1;
            end
         end
         if (rd_s && idx_s == 7 && m_rx_cnt > 0) m_rx_cnt--;
         if (tx_valid && tx_ready) begin
            if (m_txq.size() == 0) begin
               check("R7", "unexpected outgoing byte", {24'b0, tx_data}, 32'hFFFF_FFFF);
            end else begin
               check("R7", "outgoing byte order", {24'b0, tx_data}, {24'b0, m_txq[0]});
               check("R7", "end-of-frame marker", {31'b0, tx_last},
                     {31'b0, m_txq.size() == 1});
               void'(m_txq.pop_front());
               m_tx_seen++;
               if (m_txq.size() == 0) begin
                  m_send = 0; m_tx_len = 0; m_tx_fill = 0; m_txd = 1;
               end
            end
         end else if (wr_s && idx_s == 4 && !m_send) begin
            m_tx_len  = (host_wdata > 32'(DEPTH)) ? DEPTH : int'(host_wdata);
            m_tx_fill = 0;
            m_txq.delete();
         end else if (wr_s && idx_s == 8 && !m_send && m_tx_fill < m_tx_len) begin
            m_txq.push_back(host_wdata[7:0]);
            m_tx_fill++;
         end
         if (start_s) m_send = 1;
         if (wr_s && idx_s == 5) m_test = host_wdata[31];
         else if (rd_s && idx_s == 5) m_test = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R11", "irq vs model", {31'b0, irq}, {31'b0, m_txd | m_rxa | m_test});
         check("R5", "rx_ready vs model", {31'b0, rx_ready},
               {31'b0, !m_rxa && (m_rx_cnt == 0)});
         check("R7", "tx_valid vs model", {31'b0, tx_valid}, {31'b0, m_send});
      end
   end

   // ---------------- host and stream tasks ----------------
   task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b0; host_addr = a;
      #1 d = host_rdata;
      @(posedge clk);
      #1 host_req = 1'b0;
   endtask

   task automatic reg_wr(input logic [5:0] a, input logic [31:0] v);
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = v;
      @(posedge clk);
      #1 host_req = 1'b0; host_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input string what,
                         input logic [5:0] a, input logic [31:0] exp);
      logic [31:0] d;
      reg_rd(a, d);
      check(req, what, d, exp);
   endtask

   task automatic rx_send(input logic [7:0] b, input bit last);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b; rx_last = last;
      #1;
      while (!rx_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1 rx_valid = 1'b0; rx_last = 1'b0;
   endtask

   task automatic tx_drain(input logic [7:0] pat);
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (!tx_valid && m_txq.size() == 0) break;
         tx_ready = pat[i % 8];
      end
      tx_ready = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state and constant words
      rd_chk("R1", "id low word", 6'h00, 32'h5445_4E42);
      rd_chk("R1", "id high word", 6'h04, 32'h5452_4F50);
      rd_chk("R2", "busy after reset", 6'h08, 32'h0);
      rd_chk("R3", "rx count after reset", 6'h0C, 32'h0);
      rd_chk("R6", "tx count after reset", 6'h10, 32'h0);
      rd_chk("R9", "int ctrl after reset", 6'h14, 32'h0);
      rd_chk("R12", "info word", 6'h18, 32'h0000_0007);
      rd_chk("R12", "tx data port read", 6'h20, 32'h0);
      rd_chk("R12", "undecoded offset", 6'h24, 32'h0);
      rd_chk("R12", "misaligned read", 6'h1A, 32'h0);
      reg_wr(6'h18, 32'hFFFF_FFFF);
      rd_chk("R12", "info after write", 6'h18, 32'h0000_0007);
      reg_wr(6'h08, 32'h1);
      rd_chk("R2", "busy after write", 6'h08, 32'h0);

      // receive a 5-byte frame
      rx_send(8'hA0, 1'b0);
      rx_send(8'hA1, 1'b0);
      rd_chk("R2", "busy mid receive", 6'h08, 32'h1);
      rd_chk("R3", "count mid receive", 6'h0C, 32'h0);
      rx_send(8'hA2, 1'b0);
      rx_send(8'hA3, 1'b0);
      rx_send(8'hA4, 1'b1);
      rd_chk("R3", "rx count loaded", 6'h0C, 32'd5);
      rd_chk("R3", "rx available flag", 6'h14, 32'h2);
      rd_chk("R2", "busy after receive", 6'h08, 32'h0);

      // new frame blocked while flag set
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'hEE; rx_last = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1 check("R5", "ready while flag set", {31'b0, rx_ready}, 32'h0);
         @(negedge clk);
      end
      rx_valid = 1'b0; rx_last = 1'b0;
      rd_chk("R5", "count after blocked frame", 6'h0C, 32'd5);

      reg_wr(6'h14, 32'h0);
      rd_chk("R9", "write 0 keeps rx flag", 6'h14, 32'h2);
      reg_wr(6'h14, 32'h2);
      rd_chk("R9", "write 1 clears rx flag", 6'h14, 32'h0);
      @(negedge clk);
      check("R11", "irq low after clear", {31'b0, irq}, 32'h0);
      check("R5", "ready low while undrained", {31'b0, rx_ready}, 32'h0);

      for (int i = 0; i < 5; i++) begin
         rd_chk("R4", "rx byte", 6'h1C, 32'hA0 + 32'(i));
         rd_chk("R4", "rx count after pop", 6'h0C, 32'(4 - i));
      end
      rd_chk("R4", "read at zero count", 6'h1C, 32'h0);
      rd_chk("R4", "count stays zero", 6'h0C, 32'h0);
      @(negedge clk);
      check("R5", "ready after drain", {31'b0, rx_ready}, 32'h1);

      // transmit
      reg_wr(6'h10, 32'd100);
      rd_chk("R6", "length capped", 6'h10, 32'd64);
      reg_wr(6'h10, 32'd0);
      rd_chk("R6", "length zero", 6'h10, 32'd0);
      reg_wr(6'h10, 32'd4);
      reg_wr(6'h20, 32'hFFFF_FF11);
      reg_wr(6'h20, 32'h22);
      reg_wr(6'h20, 32'h33);
      reg_wr(6'h20, 32'h44);
      reg_wr(6'h20, 32'h55);
      reg_wr(6'h20, 32'h66);
      @(negedge clk);
      check("R7", "first outgoing byte", {24'b0, tx_data}, 32'h11);
      check("R7", "not last yet", {31'b0, tx_last}, 32'h0);
      rd_chk("R2", "busy while sending", 6'h08, 32'h1);
      reg_wr(6'h10, 32'd9);
      rd_chk("R6", "length write while sending", 6'h10, 32'd4);
      tx_drain(8'b1011_0101);
      check("R7", "outgoing byte total", 32'(m_tx_seen), 32'd4);
      rd_chk("R8", "tx count cleared", 6'h10, 32'h0);
      rd_chk("R8", "tx done flag", 6'h14, 32'h1);
      @(negedge clk);
      check("R11", "irq on tx done", {31'b0, irq}, 32'h1);
      reg_wr(6'h14, 32'h1);
      rd_chk("R9", "tx done cleared", 6'h14, 32'h0);

      // test interrupt
      reg_wr(6'h14, 32'h8000_0000);
      @(negedge clk);
      check("R10", "test raises irq", {31'b0, irq}, 32'h1);
      rd_chk("R10", "test bit read", 6'h14, 32'h8000_0000);
      rd_chk("R10", "test bit cleared by read", 6'h14, 32'h0);
      @(negedge clk);
      check("R11", "irq low after test read", {31'b0, irq}, 32'h0);
      reg_wr(6'h14, 32'h8000_0000);
      reg_wr(6'h14, 32'h0);
      rd_chk("R10", "test bit cleared by write 0", 6'h14, 32'h0);

      // oversize frame
      for (int i = 0; i < 70; i++) rx_send(8'(i), i == 69);
      rd_chk("R13", "truncated count", 6'h0C, 32'd64);
      for (int i = 0; i < 64; i++) rd_chk("R13", "truncated byte", 6'h1C, 32'(i));
      rd_chk("R13", "read past truncated frame", 6'h1C, 32'h0);
      reg_wr(6'h14, 32'h2);
      rd_chk("R9", "rx flag cleared", 6'h14, 32'h0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule